// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block holds the digital control and status logic of a successive-approximation converter. Software writes one 8-bit control word and reads it back. The word holds an enable, a start-conversion bit, a continuous-mode select, a completion flag, an interrupt enable and a 3-bit clock-division code. A 4-bit channel code picks one of eight digital input lanes, a fixed bandgap code, or ground. The comparator is modelled digitally: when a conversion starts, the chosen lane value is held. The block then resolves it one bit at a time, most significant bit first, against a trial register, and latches the 10-bit outcome when the conversion ends.

A conversion is counted in converter-clock ticks. The system clock is divided by the selected ratio to make these ticks. The first conversion after the enable rises is longer than later ones. In continuous mode, each completion launches the next conversion on the same edge. A registered interrupt request follows the flag, the interrupt enable and a global interrupt-enable input. An acknowledge input clears the flag in place of a vector-fetch clear.

Top module: `adc_seq`

## Requirements
- R1: After reset the control word reads 0x00, the result reads 0, and busy and irq are 0. The control word fields, from bit 7 down to bit 0, are enable, start/busy, continuous mode, flag, interrupt enable, and division code bits 2..0.
- R2: A write with bit 7 = 0 during a conversion aborts it. Busy is 0 after that edge, the flag is not set, and the result is not changed.
- R3: A write with bits 7 and 6 both 1 while idle starts a conversion on that edge. A write with bit 6 = 0 starts nothing.
- R4: Bit 6 of the read word and the busy output are 1 from the start edge until the completion edge, and 0 otherwise.
- R5: A conversion lasts 13 ticks. The first conversion after the enable goes from 0 to 1 lasts 25 ticks, and this includes a start written in the same write as the enable.
- R6: One tick is D system clocks, where D = 2 for codes 0 and 1 and D = 2^code for codes 2..7. A conversion therefore ends exactly ticks×D system clocks after its start edge.
- R7: With bit 5 = 1, every completion starts a new 13-tick conversion on the same edge, and busy stays 1. Clearing bit 5 lets the running conversion finish and starts no further one.
- R8: Every completion sets the flag on the same edge that updates the result. If a completion and a flag-clear write or an acknowledge fall on the same edge, the flag ends up set.
- R9: The flag is cleared by a write with bit 4 = 1 or by an irq_ack pulse. A write with bit 4 = 0 leaves the flag unchanged.
- R10: irq is registered. After each edge it equals the AND of the new flag, the new interrupt enable, and the gie value present at that edge.
- R11: The input is sampled at the start edge. Channel codes 0..7 select lanes 0..7, code 14 (1110) selects the constant 266, and code 15 (1111) and codes 8..13 convert to 0.
- R12: The result equals the sampled value and holds it until the next completion, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| ch_sel | input | 4 | Channel code, sampled at conversion start |
| ain | input | 80 | Eight 10-bit input lanes, lane k at bits 10k+9..10k |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ctrl_rd | output | 8 | Control word read value |
| result | output | 10 | Latched conversion result |
| busy | output | 1 | Conversion in progress |
| cclk_en | output | 1 | Converter clock tick enable |
| irq | output | 1 | Interrupt request |

## Verification
A completion setting the flag can land on the same edge as software clearing the flag, or as an acknowledge clearing it. The bench counts the exact number of system clocks from the start edge so that a flag-clear write, and separately an acknowledge pulse, fall on the completion edge. It then judges that the flag reads 1 and busy reads 0 afterwards. Abort is tested the same way: a disable write lands mid-conversion, and the flag and result must stay unchanged well past the original completion time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CW_W   = 8;
  localparam int B_EN   = 7;
  localparam int B_ST   = 6;
  localparam int B_FR   = 5;
  localparam int B_FLG  = 4;
  localparam int B_IE   = 3;
  localparam int PS_W   = 3;
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   one_sh;

  always_comb begin
    one_sh = (CNT_W+1)'(1) << ps;
    if (ps <= PS_W'(1)) lim = CNT_W'(1);
    else                lim = one_sh[CNT_W-1:0] - CNT_W'(1);
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (cnt == lim)        cnt <= '0;
    else                        cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/adc_seq_mux.sv
module adc_seq_mux #(
  parameter int RES_W   = 10,
  parameter int NCH     = 8,
  parameter int SEL_W   = 4,
  parameter int BG_SEL  = 14,
  parameter int BG_VAL  = 266
) (
  input  logic [NCH*RES_W-1:0] ain,
  input  logic [SEL_W-1:0]     sel,
  output logic [RES_W-1:0]     val
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [RES_W-1:0] lane [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane[g] = ain[g*RES_W +: RES_W];
  end

  always_comb begin
    val = '0;
    if (sel == SEL_W'(BG_SEL))
      val = RES_W'(BG_VAL);
    else if ({1'b0, sel} < (SEL_W+1)'(NCH))
      val = lane[sel[IDX_W-1:0]];
  end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int RES_W = 10,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] sample,
  input  logic             step,
  input  logic [BIT_W-1:0] bit_idx,
  output logic [RES_W-1:0] approx
);
  logic [RES_W-1:0] held;
  logic [RES_W-1:0] trial;

  assign trial = approx | (RES_W'(1) << bit_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      approx <= '0;
    end else if (load) begin
      held   <= sample;
      approx <= '0;
    end else if (step && (trial <= held)) begin
      approx <= trial;
    end
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int NCH         = 8,
  parameter int SEL_W       = 4,
  parameter int NORM_TICKS  = 13,
  parameter int FIRST_TICKS = 25,
  parameter int BG_SEL      = 14,
  parameter int BG_VAL      = 266
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           wr_data,
  input  logic [SEL_W-1:0]     ch_sel,
  input  logic [NCH*RES_W-1:0] ain,
  input  logic                 gie,
  input  logic                 irq_ack,
  output logic [7:0]           ctrl_rd,
  output logic [RES_W-1:0]     result,
  output logic                 busy,
  output logic                 cclk_en,
  output logic                 irq
);
  localparam int TW    = $clog2(FIRST_TICKS + 1);
  localparam int BIT_W = $clog2(RES_W);

  logic            en_q, fr_q, flag_q, ie_q, busy_q, first_q, irq_q;
  logic [PS_W-1:0] ps_q;
  logic [TW-1:0]   len_q, tcnt_q;
  logic [RES_W-1:0] result_q;

  logic            tick, en_rise, first_eff, abort, start_req;
  logic            last_tick, conv_done, fr_nxt, restart, launch;
  logic            flag_nxt, ie_nxt, flag_clr, busy_nxt, sar_step;
  logic [TW-1:0]   launch_len, rem;
  logic [RES_W-1:0] sample, approx;

  adc_seq_clkdiv #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst(rst), .run(busy_q), .restart(launch), .ps(ps_q), .tick(tick)
  );

  adc_seq_mux #(
    .RES_W(RES_W), .NCH(NCH), .SEL_W(SEL_W), .BG_SEL(BG_SEL), .BG_VAL(BG_VAL)
  ) u_mux (
    .ain(ain), .sel(ch_sel), .val(sample)
  );

  adc_seq_sar #(.RES_W(RES_W), .BIT_W(BIT_W)) u_sar (
    .clk(clk), .rst(rst), .load(launch), .sample(sample),
    .step(sar_step), .bit_idx(rem[BIT_W-1:0]), .approx(approx)
  );

  always_comb begin
    en_rise   = wr_en && wr_data[B_EN] && !en_q;
    first_eff = first_q || en_rise;
    abort     = wr_en && !wr_data[B_EN] && busy_q;
    start_req = wr_en && wr_data[B_EN] && wr_data[B_ST] && !busy_q;
    last_tick = busy_q && tick && (tcnt_q == len_q - TW'(1));
    conv_done = last_tick && !abort;
    fr_nxt    = wr_en ? wr_data[B_FR] : fr_q;
    ie_nxt    = wr_en ? wr_data[B_IE] : ie_q;
    restart   = conv_done && fr_nxt;
    launch    = start_req || restart;
    launch_len = (start_req && first_eff) ? TW'(FIRST_TICKS) : TW'(NORM_TICKS);

    flag_clr = (wr_en && wr_data[B_FLG]) || irq_ack;
    if (conv_done)     flag_nxt = 1'b1;
    else if (flag_clr) flag_nxt = 1'b0;
    else               flag_nxt = flag_q;

    if (launch)                  busy_nxt = 1'b1;
    else if (abort || conv_done) busy_nxt = 1'b0;
    else                         busy_nxt = busy_q;

    rem      = len_q - TW'(2) - tcnt_q;
    sar_step = busy_q && tick && (tcnt_q <= len_q - TW'(2)) && (rem < TW'(RES_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      fr_q     <= 1'b0;
      ie_q     <= 1'b0;
      ps_q     <= '0;
      flag_q   <= 1'b0;
      busy_q   <= 1'b0;
      first_q  <= 1'b0;
      irq_q    <= 1'b0;
      len_q    <= '0;
      tcnt_q   <= '0;
      result_q <= '0;
    end else begin
      if (wr_en) begin
        en_q <= wr_data[B_EN];
        fr_q <= wr_data[B_FR];
        ie_q <= wr_data[B_IE];
        ps_q <= wr_data[PS_W-1:0];
      end
      flag_q <= flag_nxt;
      busy_q <= busy_nxt;
      irq_q  <= flag_nxt && ie_nxt && gie;
      if (launch)       first_q <= 1'b0;
      else if (en_rise) first_q <= 1'b1;
      if (launch) begin
        len_q  <= launch_len;
        tcnt_q <= '0;
      end else if (busy_q && tick) begin
        tcnt_q <= tcnt_q + TW'(1);
      end
      if (conv_done) result_q <= approx;
    end
  end

  assign ctrl_rd = {en_q, busy_q, fr_q, flag_q, ie_q, ps_q};
  assign result  = result_q;
  assign busy    = busy_q;
  assign cclk_en = tick;
  assign irq     = irq_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             busy,
  input logic             irq,
  input logic             gie,
  input logic             conv_done,
  input logic             flag,
  input logic [RES_W-1:0] result
);
  p_abort_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[7]) |=> !busy);

  p_zero_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_en && !wr_data[6]) |=> !busy);

  p_flag_on_done_r8: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> flag);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie));

  p_result_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(result));
endmodule

bind adc_seq adc_seq_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .irq(irq), .gie(gie), .conv_done(conv_done), .flag(ctrl_rd[4]), .result(result)
);

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;
  localparam logic [7:0] EN = 8'h80, ST = 8'h40, FR = 8'h20, FL = 8'h10, IE = 8'h08;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [3:0]  ch_sel = 4'd0;
  logic [79:0] ain = '0;
  logic        gie = 1'b0;
  logic        irq_ack = 1'b0;
  logic [7:0]  ctrl_rd;
  logic [9:0]  result;
  logic        busy, cclk_en, irq;

  int checks = 0;
  int fails  = 0;
  int lane_v [8];

  always #4 clk = ~clk;

  adc_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ch_sel(ch_sel),
    .ain(ain), .gie(gie), .irq_ack(irq_ack), .ctrl_rd(ctrl_rd), .result(result),
    .busy(busy), .cclk_en(cclk_en), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lane(input int k, input int v);
    lane_v[k] = v;
    ain[k*10 +: 10] = 10'(v);
  endtask

  function automatic int exp_val(input int c);
    if (c < 8)   return lane_v[c];
    if (c == 14) return 266;
    return 0;
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int prev;
    for (int k = 0; k < 8; k++) set_lane(k, (k * 97 + 31) % 1024);
    set_lane(0, 1023);
    set_lane(1, 0);
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 reset ctrl", ctrl_rd, 0);
    check("R1 reset result", result, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset irq", irq, 0);

    // R5 first conversion: enable and start in the same write, 25 ticks x 2
    ch_sel = 4'd2;
    wr(EN | ST);
    ch_sel = 4'd0;
    check("R4 busy bit at start", ctrl_rd[6], 1);
    cyc(49);
    check("R5 first still busy", busy, 1);
    cyc(1);
    check("R5 first done", busy, 0);
    check("R1 ctrl layout after done", ctrl_rd, 8'h90);
    check("R12 result ch2", result, lane_v[2]);

    // R5 normal 13-tick conversion, flag cleared by the same write (R9)
    ch_sel = 4'd3;
    wr(EN | ST | FL);
    check("R9 write-one clears flag", ctrl_rd[4], 0);
    cyc(25);
    check("R4 normal still busy", ctrl_rd[6], 1);
    cyc(1);
    check("R5 normal done", busy, 0);
    check("R8 flag set", ctrl_rd[4], 1);
    check("R12 result ch3", result, lane_v[3]);

    // R3 writing start 0 does nothing; R9 flag clear
    wr(EN | FL);
    cyc(30);
    check("R3 start 0 no conversion", busy, 0);
    check("R9 flag cleared", ctrl_rd[4], 0);
    check("R12 result held", result, lane_v[3]);
    wr(EN);
    check("R9 write zero keeps flag", ctrl_rd[4], 0);

    // R11 channel sweep, sample taken at start edge
    for (int c = 0; c < 16; c++) begin
      ch_sel = 4'(c);
      wr(EN | ST | FL);
      ch_sel = 4'(15 - c);
      cyc(26);
      check("R11 channel result", result, exp_val(c));
      check("R8 flag per conversion", ctrl_rd[4], 1);
    end

    // R12 hold when inputs change
    prev = result;
    set_lane(3, 777);
    set_lane(1, 555);
    cyc(40);
    check("R12 result holds", result, prev);

    // R6 prescaler sweep
    for (int p = 0; p < 8; p++) begin
      ch_sel = 4'd3;
      wr(EN | ST | FL | 8'(p));
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (busy && n < 5000);
      check("R6 conversion length", n, 13 * ((p < 2) ? 2 : (1 << p)));
      check("R12 result ch3 new", result, 777);
    end

    // R9 acknowledge clears flag
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    check("R9 ack clears flag", ctrl_rd[4], 0);

    // R10 interrupt gating
    wr(EN | ST | IE);
    cyc(26);
    check("R10 irq off without gie", irq, 0);
    gie = 1'b1;
    cyc(1);
    check("R10 irq with gie", irq, 1);
    wr(EN);
    check("R10 irq off without ie", irq, 0);
    check("R9 write zero keeps flag set", ctrl_rd[4], 1);
    wr(EN | IE);
    check("R10 irq back on", irq, 1);
    gie = 1'b0;
    cyc(1);
    check("R10 irq follows gie", irq, 0);
    gie = 1'b1;
    wr(EN | IE | FL);
    check("R10 irq off after clear", irq, 0);
    gie = 1'b0;

    // R8 completion and flag-clear write on the same edge
    wr(EN | ST);
    cyc(25);
    wr(EN | FL);
    check("R8 set beats clear write", ctrl_rd[4], 1);
    check("R8 busy low at collision", busy, 0);
    wr(EN | FL);
    check("R9 flag clear", ctrl_rd[4], 0);
    // R8 completion and acknowledge on the same edge
    wr(EN | ST);
    cyc(25);
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    check("R8 set beats ack", ctrl_rd[4], 1);
    wr(EN | FL);

    // R2 abort
    prev = result;
    ch_sel = 4'd5;
    wr(EN | ST);
    cyc(5);
    wr(8'h00);
    check("R2 abort busy", busy, 0);
    check("R2 abort ctrl", ctrl_rd, 0);
    cyc(40);
    check("R2 no flag after abort", ctrl_rd[4], 0);
    check("R2 result unchanged", result, prev);

    // R5 re-enable then start: long conversion again
    wr(EN);
    cyc(3);
    wr(EN | ST);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (busy && n < 5000);
    check("R5 first after re-enable", n, 50);
    check("R11 ch5 result", result, lane_v[5]);

    // R7 continuous mode
    ch_sel = 4'd4;
    wr(EN | ST | FR | FL);
    cyc(25);
    check("R7 busy first run", busy, 1);
    cyc(1);
    check("R7 flag first run", ctrl_rd[4], 1);
    check("R7 busy kept", busy, 1);
    check("R7 result first", result, lane_v[4]);
    prev = lane_v[4];
    set_lane(4, 1000);
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    cyc(24);
    check("R7 flag clear mid", ctrl_rd[4], 0);
    cyc(1);
    check("R7 second completion", ctrl_rd[4], 1);
    check("R7 second result old sample", result, prev);
    wr(EN | FL);
    cyc(24);
    check("R7 last still busy", busy, 1);
    cyc(1);
    check("R7 stops after clear", busy, 0);
    check("R7 third result", result, 1000);
    cyc(30);
    check("R7 no restart", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule